// File: doc/BRIEF.md
# Systolic 2D Convolution Array

This block slides several square filter kernels over a two-dimensional image that arrives as a single raster-ordered pixel stream. Each kernel is held in a chain of multiply-accumulate cells. Every cell handles one column of kernel taps, and all rows of that column are multiplied in parallel. Partial sums move one cell along the chain for each accepted pixel. Line buffers provide the pixels of the rows above the current one, so each pixel is fetched from the stream exactly once. All kernels share the same stream and work in lock-step.

The kernel weights are written through a simple load port before the scan starts. The plane width and height are given at run time and must stay constant while a frame is in flight. Only windows that lie fully inside the plane produce a result. Each result is scaled down and passed through a saturating piecewise-linear activation. It can then be averaged over non-overlapping 2×2 blocks, or this pooling step can be bypassed. Results for all kernels appear together on one wide output word, marked by a valid flag.

Top module: `conv_systolic_array`

## Requirements
- R1: While reset is high and on the cycle after it, feat_valid is 0. Reset returns the raster position to row 0, column 0 and clears all weights to zero, so a frame streamed after reset is processed from its first pixel.
- R2: Weight tap (row r, column c) of kernel k is written at wt_addr = k*K*K + r*K + c, with K = 3. Row 0 is the topmost row of the window and column 0 is the leftmost column.
- R3: For the window whose top-left pixel is (y, x), the raw value of kernel k is the sum over r and c of w[k][r][c]*p[y+r][x+c]. Pixels and weights are 8-bit two's complement and are accumulated exactly. Kernel k's result is placed on feat_data[8k+7:8k].
- R4: Outputs are produced only for windows that fit entirely inside the plane, in raster order. This gives (H-2)*(W-2) results per frame when pooling is off. The column position always stays below plane_w.
- R5: The raw value is scaled by an arithmetic shift right of 2 bits, which rounds toward minus infinity.
- R6: With act_en = 1 the scaled value is clamped to [-64, 64]. With act_en = 0 it is clamped to [-128, 127].
- R7: With pool_en = 1 each output is floor((a+b+c+d)/4) of a non-overlapping 2×2 block of activated values, in raster order over the blocks. A trailing odd output row or column is dropped.
- R8: A cycle with pix_valid low changes no state. Results do not depend on gaps in the stream.
- R9: Frames follow one another without reset. The position wraps to (0, 0) after the last pixel of a frame, and the plane size may change between frames.
- R10: The output for a window appears on the third rising edge, counting the edge that accepts the window's bottom-right pixel as the first. For a pooled output, the relevant pixel is the bottom-right pixel of the block's last window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_we | input | 1 | Weight write strobe |
| wt_addr | input | 5 | Flat weight index (kernel, row, column) |
| wt_data | input | 8 | Signed weight value |
| plane_w | input | 4 | Plane width in pixels (3..8) |
| plane_h | input | 4 | Plane height in pixels (3..8) |
| act_en | input | 1 | Select the narrow activation clamp |
| pool_en | input | 1 | Enable 2×2 average sub-sampling |
| pix_valid | input | 1 | Pixel accepted this cycle |
| pix_data | input | 8 | Signed pixel value |
| feat_valid | output | 1 | Feature word valid |
| feat_data | output | 16 | One signed 8-bit result per kernel |

## Verification
The assertions take for granted that plane_w and plane_h are at least the kernel size and at most their maximums. They also assume that the plane size, act_en and pool_en change only between frames, and that weights are written only while no window is in flight. The stimulus keeps to these limits: every frame is set up while the stream is idle, and weights are loaded only after the previous frame's outputs have drained. Pixel and weight ranges are chosen so that both clamp limits and negative rounding are reached.

// File: rtl/conv_pkg.sv
package conv_pkg;

  typedef enum logic {
    OUT_DIRECT = 1'b0,
    OUT_POOLED = 1'b1
  } out_sel_e;

  function automatic int clamp_int(input int v, input int lo, input int hi);
    int r;
    r = v;
    if (v < lo) r = lo;
    if (v > hi) r = hi;
    return r;
  endfunction

endpackage

// File: rtl/conv_linebuf.sv
module conv_linebuf #(
  parameter int K     = 3,
  parameter int PIX_W = 8,
  parameter int MAX_W = 8,
  parameter int CW    = 3
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [CW-1:0]             col,
  input  logic [PIX_W-1:0]          pix_in,
  output logic [K-1:0][PIX_W-1:0]   col_vec
);

  // chain[0] is the current row; chain[s+1] is the row s+1 lines above
  logic [PIX_W-1:0] chain [K];

  assign chain[0] = pix_in;

  for (genvar s = 0; s < K-1; s++) begin : g_row
    logic [PIX_W-1:0] mem [MAX_W];
    assign chain[s+1] = mem[col];
    always_ff @(posedge clk) begin
      if (wr_en) mem[col] <= chain[s];
    end
  end

  // col_vec[0] is the topmost window row, col_vec[K-1] the newest
  for (genvar r = 0; r < K; r++) begin : g_out
    assign col_vec[r] = chain[K-1-r];
  end

endmodule

// File: rtl/conv_mac_cell.sv
module conv_mac_cell #(
  parameter int K     = 3,
  parameter int PIX_W = 8,
  parameter int W_W   = 8,
  parameter int ACC_W = 24
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [K-1:0][PIX_W-1:0]   col_vec,
  input  logic [K-1:0][W_W-1:0]     wcol,
  input  logic signed [ACC_W-1:0]   sum_in,
  output logic signed [ACC_W-1:0]   sum_out
);

  logic signed [ACC_W-1:0] tap_sum;

  always_comb begin
    tap_sum = sum_in;
    for (int r = 0; r < K; r++) begin
      tap_sum = tap_sum + ACC_W'($signed(wcol[r]) * $signed(col_vec[r]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     sum_out <= '0;
    else if (en) sum_out <= tap_sum;
  end

endmodule

// File: rtl/conv_post.sv
module conv_post
  import conv_pkg::*;
#(
  parameter int ACC_W   = 24,
  parameter int OUT_W   = 8,
  parameter int SHIFT   = 2,
  parameter int ACT_LIM = 64,
  parameter int PWW     = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [ACC_W-1:0]  acc,
  input  logic                     act_en,
  input  logic                     pool_en,
  input  logic [PWW-1:0]           ocol,
  input  logic                     orow_odd,
  output logic                     out_valid,
  output logic [OUT_W-1:0]         out_data
);

  localparam int HB_D  = 1 << (PWW-1);
  localparam int FULLP = (1 << (OUT_W-1)) - 1;
  localparam int FULLN = -(1 << (OUT_W-1));

  // stage A: scale and activation
  int scaled, lo, hi, clamped;
  always_comb begin
    scaled  = int'(acc >>> SHIFT);
    lo      = act_en ? -ACT_LIM : FULLN;
    hi      = act_en ? ACT_LIM  : FULLP;
    clamped = clamp_int(scaled, lo, hi);
  end

  logic                    vA, limA, oddA;
  logic signed [OUT_W-1:0] actA;
  logic [PWW-1:0]          ocolA;
  out_sel_e                selA, selB;

  always_ff @(posedge clk) begin
    if (rst) begin
      vA    <= 1'b0;
      limA  <= 1'b0;
      oddA  <= 1'b0;
      actA  <= '0;
      ocolA <= '0;
      selA  <= OUT_DIRECT;
    end else begin
      vA <= in_valid;
      if (in_valid) begin
        actA  <= OUT_W'(clamped);
        limA  <= act_en;
        ocolA <= ocol;
        oddA  <= orow_odd;
        selA  <= pool_en ? OUT_POOLED : OUT_DIRECT;
      end
    end
  end

  // stage B: optional 2x2 average
  logic signed [OUT_W:0]   hbuf [HB_D];
  logic signed [OUT_W-1:0] hold;
  logic signed [OUT_W:0]   pair, hbuf_rd;
  logic signed [OUT_W+1:0] sum4;
  logic                    hb_we;

  assign hbuf_rd = hbuf[ocolA[PWW-1:1]];
  assign pair    = (OUT_W+1)'(hold) + (OUT_W+1)'(actA);
  assign sum4    = (OUT_W+2)'(hbuf_rd) + (OUT_W+2)'(pair);
  assign hb_we   = vA && (selA == OUT_POOLED) && ocolA[0] && !oddA;

  always_ff @(posedge clk) begin
    if (hb_we) hbuf[ocolA[PWW-1:1]] <= pair;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      hold      <= '0;
      selB      <= OUT_DIRECT;
    end else begin
      out_valid <= 1'b0;
      if (vA) begin
        selB <= selA;
        if (selA == OUT_DIRECT) begin
          out_valid <= 1'b1;
          out_data  <= actA;
        end else if (!ocolA[0]) begin
          hold <= actA;
        end else if (oddA) begin
          out_valid <= 1'b1;
          out_data  <= OUT_W'(sum4 >>> 2);
        end
      end
    end
  end

  // R6: activated value respects the narrow clamp
  a_r6_act_bound: assert property (@(posedge clk) disable iff (rst)
    (vA && limA) |-> ((int'(actA) >= -ACT_LIM) && (int'(actA) <= ACT_LIM)));

  // R7: pooled outputs are never produced on back-to-back cycles
  a_r7_pool_spacing: assert property (@(posedge clk) disable iff (rst)
    (out_valid && selB == OUT_POOLED) |=> !out_valid);

endmodule

// File: rtl/conv_systolic_array.sv
module conv_systolic_array #(
  parameter int K       = 3,
  parameter int L       = 2,
  parameter int MAX_W   = 8,
  parameter int MAX_H   = 8,
  parameter int PIX_W   = 8,
  parameter int W_W     = 8,
  parameter int ACC_W   = 24,
  parameter int OUT_W   = 8,
  parameter int SHIFT   = 2,
  parameter int ACT_LIM = 64,
  localparam int TAPS   = K*K,
  localparam int NW     = L*TAPS,
  localparam int WAW    = $clog2(NW),
  localparam int PWW    = $clog2(MAX_W+1),
  localparam int PHW    = $clog2(MAX_H+1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wt_we,
  input  logic [WAW-1:0]       wt_addr,
  input  logic [W_W-1:0]       wt_data,
  input  logic [PWW-1:0]       plane_w,
  input  logic [PHW-1:0]       plane_h,
  input  logic                 act_en,
  input  logic                 pool_en,
  input  logic                 pix_valid,
  input  logic [PIX_W-1:0]     pix_data,
  output logic                 feat_valid,
  output logic [L*OUT_W-1:0]   feat_data
);

  localparam int   CW   = $clog2(MAX_W);
  localparam logic KODD = 1'((K-1) % 2);

  // weight store
  logic [W_W-1:0] wt_q [NW];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) wt_q[i] <= '0;
    end else if (wt_we && (int'(wt_addr) < NW)) begin
      wt_q[wt_addr] <= wt_data;
    end
  end

  // raster position
  logic [PWW-1:0] col;
  logic [PHW-1:0] row;
  logic           last_col, last_row, win_ok;

  assign last_col = (col == plane_w - 1'b1);
  assign last_row = (row == plane_h - 1'b1);
  assign win_ok   = (col >= PWW'(K-1)) && (row >= PHW'(K-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0;
      row <= '0;
    end else if (pix_valid) begin
      if (last_col) begin
        col <= '0;
        row <= last_row ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  logic           vld1, oodd1;
  logic [PWW-1:0] ocol1;
  always_ff @(posedge clk) begin
    if (rst) begin
      vld1  <= 1'b0;
      oodd1 <= 1'b0;
      ocol1 <= '0;
    end else begin
      vld1 <= pix_valid && win_ok;
      if (pix_valid) begin
        ocol1 <= col - PWW'(K-1);
        oodd1 <= row[0] ^ KODD;
      end
    end
  end

  // column vector from line buffers
  logic [K-1:0][PIX_W-1:0] col_vec;

  conv_linebuf #(.K(K), .PIX_W(PIX_W), .MAX_W(MAX_W), .CW(CW)) u_lb (
    .clk     (clk),
    .wr_en   (pix_valid),
    .col     (col[CW-1:0]),
    .pix_in  (pix_data),
    .col_vec (col_vec)
  );

  // per-kernel systolic chain and post-processing
  logic signed [ACC_W-1:0] psum [L][K+1];
  logic [L-1:0]            v_all;

  for (genvar k = 0; k < L; k++) begin : g_k
    assign psum[k][0] = '0;
    for (genvar j = 0; j < K; j++) begin : g_j
      logic [K-1:0][W_W-1:0] wcol;
      for (genvar r = 0; r < K; r++) begin : g_r
        assign wcol[r] = wt_q[k*TAPS + r*K + j];
      end
      conv_mac_cell #(.K(K), .PIX_W(PIX_W), .W_W(W_W), .ACC_W(ACC_W)) u_cell (
        .clk     (clk),
        .rst     (rst),
        .en      (pix_valid),
        .col_vec (col_vec),
        .wcol    (wcol),
        .sum_in  (psum[k][j]),
        .sum_out (psum[k][j+1])
      );
    end
    conv_post #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT),
                .ACT_LIM(ACT_LIM), .PWW(PWW)) u_post (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (vld1),
      .acc       (psum[k][K]),
      .act_en    (act_en),
      .pool_en   (pool_en),
      .ocol      (ocol1),
      .orow_odd  (oodd1),
      .out_valid (v_all[k]),
      .out_data  (feat_data[k*OUT_W +: OUT_W])
    );
  end

  assign feat_valid = |v_all;

  // R1: reset silences the output on the following cycle
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !feat_valid);

  // R4: raster column never reaches the plane width
  a_r4_col_bound: assert property (@(posedge clk) disable iff (rst)
    col < plane_w);

  // R8: an idle stream cycle leaves the raster position untouched
  a_r8_stall_holds: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> ($stable(col) && $stable(row)));

  // R10: every output is backed by a pixel accepted three edges earlier
  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    feat_valid |-> $past(pix_valid, 3));

endmodule

// File: tb/tb_conv_systolic_array.sv
module tb_conv_systolic_array;

  localparam int K = 3, L = 2, MAX_W = 8, MAX_H = 8, OUT_W = 8;
  localparam int NW = L*K*K;

  // {count[27:20], w[19:16], h[15:12], act[11], pool[10], gap[9:8], seed[7:0]}
  localparam logic [27:0] CFG [6] = '{
    {8'd9,  4'd5, 4'd5, 1'b0, 1'b0, 2'd0, 8'd1},
    {8'd36, 4'd8, 4'd8, 1'b1, 1'b0, 2'd0, 8'd2},
    {8'd6,  4'd8, 4'd6, 1'b1, 1'b1, 2'd0, 8'd3},
    {8'd4,  4'd7, 4'd7, 1'b0, 1'b1, 2'd2, 8'd4},
    {8'd1,  4'd3, 4'd3, 1'b0, 1'b0, 2'd1, 8'd5},
    {8'd2,  4'd6, 4'd4, 1'b1, 1'b1, 2'd1, 8'd6}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic wt_we = 1'b0;
  logic [4:0] wt_addr = '0;
  logic [7:0] wt_data = '0;
  logic [3:0] plane_w = 4'd3, plane_h = 4'd3;
  logic act_en = 1'b0, pool_en = 1'b0, pix_valid = 1'b0;
  logic [7:0] pix_data = '0;
  logic feat_valid;
  logic [L*OUT_W-1:0] feat_data;

  always #5 clk = ~clk;

  conv_systolic_array dut (
    .clk(clk), .rst(rst), .wt_we(wt_we), .wt_addr(wt_addr), .wt_data(wt_data),
    .plane_w(plane_w), .plane_h(plane_h), .act_en(act_en), .pool_en(pool_en),
    .pix_valid(pix_valid), .pix_data(pix_data),
    .feat_valid(feat_valid), .feat_data(feat_data)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  int img [MAX_H][MAX_W];
  int wt  [L][K][K];
  int act_m [L][MAX_H][MAX_W];
  int acc_cyc [MAX_H][MAX_W];
  int exp_val [64][L];
  int exp_r [64];
  int exp_c [64];
  int exp_n = 0, got_n = 0;
  int last_out [L];
  string cur_tag = "R3";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int actv, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, actv, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && feat_valid) begin
      if (got_n >= exp_n) begin
        check(1'b0, "R4", "output beyond expected count", got_n + 1, exp_n);
      end else begin
        for (int k = 0; k < L; k++) begin
          last_out[k] = int'($signed(feat_data[k*OUT_W +: OUT_W]));
          check(last_out[k] == exp_val[got_n][k], cur_tag, "feature value",
                last_out[k], exp_val[got_n][k]);
        end
        check(cyc == acc_cyc[exp_r[got_n]][exp_c[got_n]] + 2, "R10",
              "output cycle", cyc, acc_cyc[exp_r[got_n]][exp_c[got_n]] + 2);
      end
      got_n++;
    end
  end

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic load_weights();
    for (int k = 0; k < L; k++)
      for (int r = 0; r < K; r++)
        for (int c = 0; c < K; c++) begin
          @(negedge clk);
          wt_we   = 1'b1;
          wt_addr = 5'(k*K*K + r*K + c);   // R2 address layout
          wt_data = 8'(wt[k][r][c]);
        end
    @(negedge clk);
    wt_we = 1'b0;
  endtask

  task automatic fill_img(input int seed);
    for (int i = 0; i < MAX_H; i++)
      for (int j = 0; j < MAX_W; j++)
        img[i][j] = ((seed*31 + i*17 + j*11 + i*j*5) % 31) - 15;
  endtask

  task automatic fill_wt(input int seed);
    for (int k = 0; k < L; k++)
      for (int r = 0; r < K; r++)
        for (int c = 0; c < K; c++)
          wt[k][r][c] = ((seed*7 + k*23 + r*5 + c*3 + r*c) % 17) - 8;
  endtask

  task automatic run_frame(input int w, input int h, input bit ae, input bit pe,
                           input int gap);
    int cr, cc, lo, hi, raw;
    cr = h - K + 1;
    cc = w - K + 1;
    lo = ae ? -64 : -128;
    hi = ae ? 64 : 127;
    for (int y = 0; y < cr; y++)
      for (int x = 0; x < cc; x++)
        for (int k = 0; k < L; k++) begin
          raw = 0;
          for (int r = 0; r < K; r++)
            for (int c = 0; c < K; c++)
              raw += wt[k][r][c] * img[y+r][x+c];
          act_m[k][y][x] = clampi(raw >>> 2, lo, hi);
        end
    exp_n = 0;
    if (!pe) begin
      for (int y = 0; y < cr; y++)
        for (int x = 0; x < cc; x++) begin
          for (int k = 0; k < L; k++) exp_val[exp_n][k] = act_m[k][y][x];
          exp_r[exp_n] = y + K - 1;
          exp_c[exp_n] = x + K - 1;
          exp_n++;
        end
    end else begin
      for (int y = 0; y < cr/2; y++)
        for (int x = 0; x < cc/2; x++) begin
          for (int k = 0; k < L; k++)
            exp_val[exp_n][k] = (act_m[k][2*y][2*x] + act_m[k][2*y][2*x+1] +
                                 act_m[k][2*y+1][2*x] + act_m[k][2*y+1][2*x+1]) >>> 2;
          exp_r[exp_n] = 2*y + K;
          exp_c[exp_n] = 2*x + K;
          exp_n++;
        end
    end
    @(negedge clk);
    plane_w = 4'(w);
    plane_h = 4'(h);
    act_en  = ae;
    pool_en = pe;
    got_n   = 0;
    for (int i = 0; i < h; i++)
      for (int j = 0; j < w; j++) begin
        pix_valid = 1'b1;
        pix_data  = 8'(img[i][j]);
        @(negedge clk);
        acc_cyc[i][j] = cyc;
        pix_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
    repeat (6) @(negedge clk);
    check(got_n == exp_n, "R4", "output count", got_n, exp_n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(feat_valid == 1'b0, "R1", "valid during reset", int'(feat_valid), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(feat_valid == 1'b0, "R1", "valid after reset", int'(feat_valid), 0);

    // table walk; frames run back to back without reset (R9)
    foreach (CFG[t]) begin
      int gp;
      gp = int'(CFG[t][9:8]);
      if (gp > 0)          cur_tag = "R8";
      else if (CFG[t][10]) cur_tag = "R7";
      else if (CFG[t][11]) cur_tag = "R6";
      else                 cur_tag = "R3";
      fill_wt(int'(CFG[t][7:0]));
      fill_img(int'(CFG[t][7:0]));
      load_weights();
      run_frame(int'(CFG[t][19:16]), int'(CFG[t][15:12]), CFG[t][11], CFG[t][10], gp);
      check(got_n == int'(CFG[t][27:20]), "R4", "table count", got_n,
            int'(CFG[t][27:20]));
    end

    // R2: single taps pick out known pixels
    cur_tag = "R2";
    foreach (wt[k, r, c]) wt[k][r][c] = 0;
    wt[0][2][0] = 4;
    wt[1][0][2] = 4;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) img[i][j] = i*3 + j + 1;
    load_weights();
    run_frame(3, 3, 1'b0, 1'b0, 0);
    check(last_out[0] == 7, "R2", "kernel0 bottom-left tap", last_out[0], 7);
    check(last_out[1] == 3, "R2", "kernel1 top-right tap", last_out[1], 3);

    // R5: negative rounding of the scale shift
    cur_tag = "R5";
    foreach (wt[k, r, c]) wt[k][r][c] = 0;
    wt[0][2][2] = 1;
    wt[1][2][2] = -3;
    img[2][2] = -5;
    load_weights();
    run_frame(3, 3, 1'b0, 1'b0, 0);
    check(last_out[0] == -2, "R5", "floor of -5/4", last_out[0], -2);
    check(last_out[1] == 3, "R5", "floor of 15/4", last_out[1], 3);

    // R9: plane size changes between frames without reset
    cur_tag = "R9";
    fill_wt(9);
    fill_img(9);
    load_weights();
    run_frame(4, 4, 1'b1, 1'b0, 0);
    run_frame(6, 5, 1'b0, 1'b0, 0);

    // R1: reset in mid-frame restarts the raster and clears weights
    cur_tag = "R1";
    @(negedge clk);
    plane_w = 4'd5;
    plane_h = 4'd5;
    exp_n = 0;
    got_n = 0;
    for (int j = 0; j < 7; j++) begin
      pix_valid = 1'b1;
      pix_data  = 8'(j + 3);
      @(negedge clk);
    end
    pix_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    foreach (wt[k, r, c]) wt[k][r][c] = 0;
    run_frame(3, 3, 1'b0, 1'b0, 0);
    check(last_out[0] == 0 && last_out[1] == 0, "R1", "weights cleared",
          last_out[0] + last_out[1], 0);
    fill_wt(11);
    fill_img(11);
    load_weights();
    run_frame(5, 5, 1'b1, 1'b0, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule